// File: doc/BRIEF.md
# Reset Button Hold-Time Classifier

This block watches a single reset push button and sorts each press into one of two requests by how long it is held. A clock-enable tick paces all timing. A rising press edge starts a short confirmation window. If the button is still down when that window closes, the press is accepted and a long-hold window starts. The press is judged when the long-hold window closes. A button that is already released by then produces a plain reboot request. A button that is still held sets a persistent "restore defaults" latch and produces the same reboot request.

The latch steers two active-low chip selects. While the latch is clear, the settings memory (NVRAM) is selected. While it is set, the read-only defaults memory is selected. The latch survives the reboot that the block itself requests. Only a power-on reset or the boot firmware's clear strobe returns it to zero. Once firmware has cleared it, the NVRAM is selected again and can be rewritten with good values. Before a new press can be classified, the button must first be seen released.

Top module: `rbc_classifier`

## Requirements
- R1: While and after power-on reset (`rst_n` low), `reboot_pulse` is 0, `defaults_q` is 0, `nvram_cs_n` is 0 and `rom_cs_n` is 1.
- R2: Exactly one chip select is active (low) at all times. `nvram_cs_n` equals `defaults_q` and `rom_cs_n` is its complement.
- R3: A press is re-checked DEB_TICKS ticks after its rising edge (seen after the input synchronizer). If the button is not held at that check, the press is discarded: no reboot request, latch unchanged, block armed again.
- R4: For a confirmed press that has been released by the moment LONG_TICKS ticks after confirmation, `reboot_pulse` is raised once and `defaults_q` is unchanged.
- R5: For a confirmed press still held at that moment, `defaults_q` becomes 1 in the same cycle as the single `reboot_pulse`.
- R6: `reboot_pulse` is high for exactly one clock cycle per classified press.
- R7: Edges on the button between the first accepted edge and the return to idle are ignored. After a reboot request the block waits for release, so a button held beyond the decision produces no further request.
- R8: `fw_clear` high at a clock edge clears `defaults_q`. When a long-hold decision falls in the same cycle, setting wins.
- R9: `defaults_q` is cleared by nothing other than `fw_clear` and power-on reset. In particular, the reboot request does not clear it.
- R10: All timing advances only on cycles where `tick` is high. With `tick` held low, a press is never classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | Clock enable that paces both timing windows |
| btn_pressed | input | 1 | Raw button level, 1 = pressed (asynchronous) |
| fw_clear | input | 1 | Firmware strobe that clears the defaults latch |
| reboot_pulse | output | 1 | One-cycle reboot request |
| defaults_q | output | 1 | Persistent restore-defaults latch |
| nvram_cs_n | output | 1 | Active-low select for the settings memory |
| rom_cs_n | output | 1 | Active-low select for the defaults memory |

## Verification
Each stimulus pattern is chosen to separate one outcome from the others:
- A glitch shorter than the confirmation window shows that debounce rejection produces no request.
- A press released inside the long window shows the ordinary-reboot path.
- A press held past the long window shows the defaults path and the wait-for-release behaviour.
- A release and re-press inside the long window shows that mid-press edges are ignored and that only the level at the decision counts.
- Holding `fw_clear` across a long-hold decision shows the set-over-clear priority.
- A press made with the tick stopped shows that time is counted only in ticks.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_CONFIRM  = 2'd1,
      PH_HOLD     = 2'd2,
      PH_RELEASE  = 2'd3
   } rbc_phase_t;
endpackage

// File: rtl/rbc_sync.sv
module rbc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rbc_fsm.sv
module rbc_fsm
   import rbc_pkg::*;
#(
   parameter int DEB_TICKS  = 5,
   parameter int LONG_TICKS = 20,
   localparam int MAX_TICKS = (DEB_TICKS > LONG_TICKS) ? DEB_TICKS : LONG_TICKS,
   localparam int CNT_W     = $clog2(MAX_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic btn_lvl,
   output logic decide
);
   localparam logic [CNT_W-1:0] DEB_LAST  = CNT_W'(DEB_TICKS - 1);
   localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_TICKS - 1);

   rbc_phase_t       phase;
   logic [CNT_W-1:0] cnt;
   logic             btn_prev;
   logic             press_edge;

   assign press_edge = btn_lvl & ~btn_prev;
   assign decide     = (phase == PH_HOLD) && tick && (cnt == LONG_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         btn_prev <= 1'b0;
      end else begin
         btn_prev <= btn_lvl;
         unique case (phase)
            PH_IDLE: begin
               if (press_edge) begin
                  phase <= PH_CONFIRM;
                  cnt   <= '0;
               end
            end
            PH_CONFIRM: begin
               if (tick) begin
                  if (cnt == DEB_LAST) begin
                     phase <= btn_lvl ? PH_HOLD : PH_IDLE;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            PH_HOLD: begin
               if (tick) begin
                  if (cnt == LONG_LAST) phase <= PH_RELEASE;
                  else                  cnt   <= cnt + 1'b1;
               end
            end
            PH_RELEASE: begin
               if (!btn_lvl) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rbc_mode_latch.sv
module rbc_mode_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic q,
   output logic nvram_cs_n,
   output logic rom_cs_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (set_req) q <= 1'b1;
      else if (clr_req) q <= 1'b0;
   end

   assign nvram_cs_n = q;
   assign rom_cs_n   = ~q;
endmodule

// File: rtl/rbc_classifier.sv
module rbc_classifier #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_TICKS   = 5,
   parameter int LONG_TICKS  = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic btn_pressed,
   input  logic fw_clear,
   output logic reboot_pulse,
   output logic defaults_q,
   output logic nvram_cs_n,
   output logic rom_cs_n
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
      if (DEB_TICKS < 1)   $error("DEB_TICKS must be at least 1");
      if (LONG_TICKS < 1)  $error("LONG_TICKS must be at least 1");
   end

   logic btn_lvl;
   logic decide;

   rbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (btn_pressed),
      .q_sync  (btn_lvl)
   );

   rbc_fsm #(.DEB_TICKS(DEB_TICKS), .LONG_TICKS(LONG_TICKS)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .btn_lvl (btn_lvl),
      .decide  (decide)
   );

   rbc_mode_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_req    (decide & btn_lvl),
      .clr_req    (fw_clear),
      .q          (defaults_q),
      .nvram_cs_n (nvram_cs_n),
      .rom_cs_n   (rom_cs_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reboot_pulse <= 1'b0;
      else        reboot_pulse <= decide;
   end
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker (
   input logic clk,
   input logic rst_n,
   input logic fw_clear,
   input logic reboot_pulse,
   input logic defaults_q,
   input logic nvram_cs_n,
   input logic rom_cs_n
);
   a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      nvram_cs_n != rom_cs_n);

   a_r5_set_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(defaults_q) |-> reboot_pulse);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reboot_pulse |=> !reboot_pulse);

   a_r8_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
      fw_clear |=> (!defaults_q || reboot_pulse));

   a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(defaults_q) |-> $past(fw_clear));
endmodule

bind rbc_classifier rbc_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fw_clear     (fw_clear),
   .reboot_pulse (reboot_pulse),
   .defaults_q   (defaults_q),
   .nvram_cs_n   (nvram_cs_n),
   .rom_cs_n     (rom_cs_n)
);

// File: tb/sim_rbc_classifier.sv
`timescale 1ns/1ps
module sim_rbc_classifier;
   localparam int SYNC = 2;
   localparam int DEB  = 5;
   localparam int LONG = 20;
   localparam int TDIV = 4;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, btn = 1'b0, fw_clear = 1'b0;
   logic reboot_pulse, defaults_q, nvram_cs_n, rom_cs_n;

   int  checks = 0, errors = 0, pulses = 0, cyc = 0, tcnt = 0;
   bit  tick_en = 1'b1;
   bit  q_at_pulse = 1'b0;
   bit  done = 1'b0;

   rbc_classifier #(.SYNC_STAGES(SYNC), .DEB_TICKS(DEB), .LONG_TICKS(LONG)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .btn_pressed(btn), .fw_clear(fw_clear),
      .reboot_pulse(reboot_pulse), .defaults_q(defaults_q),
      .nvram_cs_n(nvram_cs_n), .rom_cs_n(rom_cs_n));

   always #2.5 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // tick generator, driven away from the active edge
   always @(negedge clk) begin
      tcnt = (tcnt + 1) % TDIV;
      tick <= tick_en && (tcnt == 0);
   end

   // behavioural reference model
   int m_phase = 0, m_cnt = 0;
   bit m_q = 1'b0, m_pulse = 1'b0, m_prev = 1'b0;
   bit sq[$];
   initial for (int i = 0; i < SYNC; i++) sq.push_back(1'b0);

   always @(posedge clk) begin
      bit bs, dec;
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_q = 0; m_pulse = 0; m_prev = 0;
         sq.delete();
         for (int i = 0; i < SYNC; i++) sq.push_back(1'b0);
      end else begin
         bs  = sq[0];
         dec = (m_phase == 2) && tick && (m_cnt == LONG - 1);
         m_pulse = dec;
         if (dec && bs)     m_q = 1'b1;
         else if (fw_clear) m_q = 1'b0;
         case (m_phase)
            0: if (bs && !m_prev) begin m_phase = 1; m_cnt = 0; end
            1: if (tick) begin
                  if (m_cnt == DEB - 1) begin m_phase = bs ? 2 : 0; m_cnt = 0; end
                  else m_cnt++;
               end
            2: if (tick) begin
                  if (dec) m_phase = 3;
                  else     m_cnt++;
               end
            default: if (!bs) m_phase = 0;
         endcase
         m_prev = bs;
         void'(sq.pop_front());
         sq.push_back(btn);
      end
   end

   // per-cycle comparison and pulse bookkeeping
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R4 R5 R6 per-cycle reboot_pulse", reboot_pulse, m_pulse);
         chk("R8 R9 per-cycle defaults_q", defaults_q, m_q);
         chk("R2 per-cycle nvram_cs_n", nvram_cs_n, m_q);
         chk("R2 per-cycle rom_cs_n", rom_cs_n, !m_q);
         if (reboot_pulse) begin
            pulses++;
            q_at_pulse = defaults_q;
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         finish_run();
      end
   end

   initial begin
      int p0;
      wait_cyc(6);
      // R1: reset state
      chk("R1 reboot_pulse in reset", reboot_pulse, 0);
      chk("R1 defaults_q in reset", defaults_q, 0);
      chk("R1 nvram_cs_n in reset", nvram_cs_n, 0);
      chk("R1 rom_cs_n in reset", rom_cs_n, 1);
      rst_n = 1'b1;
      wait_cyc(10);

      // R3: glitch shorter than confirmation window
      p0 = pulses;
      btn = 1'b1; wait_cyc(8); btn = 1'b0; wait_cyc(200);
      chk("R3 glitch gives no request", pulses - p0, 0);
      chk("R3 glitch leaves latch", defaults_q, 0);

      // R4: short confirmed press
      p0 = pulses;
      btn = 1'b1; wait_cyc(60); btn = 1'b0; wait_cyc(200);
      chk("R4 short press one request", pulses - p0, 1);
      chk("R4 short press latch clear", defaults_q, 0);

      // R5/R7: long press held well past decision
      p0 = pulses;
      btn = 1'b1; wait_cyc(400);
      chk("R5 long press one request", pulses - p0, 1);
      chk("R5 latch set at request", q_at_pulse, 1);
      chk("R7 no repeat while held", pulses - p0, 1);
      btn = 1'b0; wait_cyc(50);
      chk("R9 latch survives own reboot", defaults_q, 1);
      chk("R2 rom selected", rom_cs_n, 0);

      // R8: firmware clear
      fw_clear = 1'b1; wait_cyc(1); fw_clear = 1'b0; wait_cyc(2);
      chk("R8 clear drops latch", defaults_q, 0);
      chk("R2 nvram selected again", nvram_cs_n, 0);

      // R7: release and re-press during hold, held at decision
      p0 = pulses;
      btn = 1'b1; wait_cyc(40); btn = 1'b0; wait_cyc(10); btn = 1'b1; wait_cyc(200);
      chk("R7 re-press ignored, one request", pulses - p0, 1);
      chk("R7 level at decision sets latch", defaults_q, 1);
      btn = 1'b0; wait_cyc(20);
      fw_clear = 1'b1; wait_cyc(1); fw_clear = 1'b0; wait_cyc(2);

      // R8: set wins over a clear held through the decision
      p0 = pulses;
      fw_clear = 1'b1; btn = 1'b1; wait_cyc(200);
      chk("R8 request seen under clear", pulses - p0, 1);
      chk("R8 set wins over clear", q_at_pulse, 1);
      chk("R8 clear applies afterwards", defaults_q, 0);
      btn = 1'b0; fw_clear = 1'b0; wait_cyc(20);

      // R10: no tick, no classification
      p0 = pulses;
      tick_en = 1'b0; btn = 1'b1; wait_cyc(400);
      chk("R10 no request without tick", pulses - p0, 0);
      btn = 1'b0; wait_cyc(10); tick_en = 1'b1; wait_cyc(200);
      chk("R10 stale press discarded", pulses - p0, 0);
      btn = 1'b1; wait_cyc(60); btn = 1'b0; wait_cyc(200);
      chk("R4 short press after tick restart", pulses - p0, 1);
      chk("R4 latch still clear", defaults_q, 0);

      finish_run();
   end
endmodule